// File: doc/BRIEF.md
# Supply Rail Sequencer with I2C Bus Recovery

This block brings a board up from a raw power-on reset. It turns on three supply rails one at a time: the core rail first, then the DDR I/O rail, then the 3.3 V I/O rail. Each rail must report power-good and then hold good for a settle window before the next rail is enabled. The settle window of the last rail also serves as the delay before the system reset is released. A watchdog bounds the whole ramp. If a rail does not come up in time, or a rail that has already reported good drops out, the block enters a fault state. In that state every rail is off and the system stays in reset until the next raw reset.

Once the system reset is released, the block takes over the I2C clock line. It issues a fixed burst of recovery clocks, so that any slave left mid-transfer by the power-up lets go of the data line. It then drives a STOP condition and returns both lines to the normal I2C logic. The data line is only ever pulled low, and only while the system reset is released. The block is clocked at 12 MHz, and all delays are counted in cycles of that clock.

Top module: `pwr_seq_unlock`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is deasserted after that edge: `rail_en` = 0, `sys_rst_n` = 0, `scl_ovr_en` = 0, `scl_ovr_lvl` = 0, `sda_pull_low` = 0, `seq_done` = 0.
- R2: Rails turn on in a fixed order with cumulative enables. `rail_en` bit 0 is the core rail, bit 1 the DDR I/O rail and bit 2 the 3.3 V I/O rail. Bit 0 rises on the first clock edge after `rst_n` is seen high.
- R3: Suppose rail i is enabled after edge k, and its power-good is first high at edge k+D+1. Then rail i+1 is enabled after edge k+D+1+SETTLE_CYC. The settle delay is exact.
- R4: `sys_rst_n` rises SETTLE_CYC edges after the edge that first sees power-good of the last rail. The same formula as R3 applies.
- R5: Count the cycles spent ramping or settling. If the sequence has not released `sys_rst_n` when that count reaches WDOG_CYC, all outputs drop one edge later. The block then stays faulted, whatever power-good does, until `rst_n` goes low.
- R6: If the power-good of a rail that has already been seen good goes low, all outputs drop after the next edge. This holds in every state, including after done.
- R7: From the edge that releases `sys_rst_n`, `scl_ovr_en` is high. `scl_ovr_lvl` then runs exactly SCL_PULSES periods of 2·SCL_HALF cycles, each low for SCL_HALF cycles and then high for SCL_HALF cycles. `sda_pull_low` stays 0 throughout.
- R8: After the burst comes a STOP condition of three phases, each SCL_HALF cycles long. In the first phase SCL is low and SDA is pulled low. In the second, SCL is high and SDA is still pulled low. In the third, SCL is high and SDA is released. SDA is therefore released while SCL is high.
- R9: After the STOP condition, `seq_done` = 1 and `scl_ovr_en` = 0, with all rails on and `sys_rst_n` high. This happens 19·SCL_HALF edges after `sys_rst_n` rises, for the default of 8 pulses.
- R10: `sda_pull_low` is never 1 while `sys_rst_n` is 0.
- R11: `scl_ovr_lvl` rises exactly SCL_PULSES+1 times during a full sequence: once per recovery pulse, plus once in the STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Raw power-on reset, active low, sampled synchronously |
| rail_pg | input | NUM_RAILS | Power-good per rail, bit 0 core |
| rail_en | output | NUM_RAILS | Rail enables, bit 0 core, bit 1 DDR I/O, bit 2 3.3 V I/O |
| sys_rst_n | output | 1 | System reset, active low |
| scl_ovr_en | output | 1 | SCL is driven by this block when high |
| scl_ovr_lvl | output | 1 | SCL level while overridden |
| sda_pull_low | output | 1 | Pull SDA low (open-drain) |
| seq_done | output | 1 | Startup and bus recovery complete |

## Verification
Every output comes straight from the registered state or from a counter, so each result is due a fixed number of edges after its cause. Rail i+1 is due D+1+SETTLE_CYC edges after rail i turns on, where D is the power-good delay the bench applies. Reset release follows the same rule, the burst lasts 16·SCL_HALF edges, and done arrives 19·SCL_HALF edges after reset release. A fault is visible one edge after a power-good drop, or WDOG_CYC+1 edges after reset release. The bench drives rst_n and power-good on falling edges and samples every output at the following falling edge. It numbers those samples from the reset release, computes each expected sample index from these formulas, and compares the recorded first-occurrence index against it. That way an output one cycle early or late is reported.

// File: rtl/pwrseq_pkg.sv
// Shared types for the supply-rail sequencer.
// Assumes: one clock domain, synchronous active-low reset.
package pwrseq_pkg;

    // Top-level sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_SETTLE,
        ST_BURST,
        ST_STOP,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/seq_timer.sv
// Loadable down-counter used for settle, STOP-phase and watchdog timing.
// Loading takes priority over decrementing, and the count holds at zero.
// Assumes: load_val fits in WIDTH bits.
module seq_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic [WIDTH-1:0] count,
    output logic             zero
);

    logic [WIDTH-1:0] cnt_q;

    // Counter register: load, or step down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

endmodule

// File: rtl/scl_burst.sv
// Generates PULSES clock periods on SCL while run is high. Each period is
// low for HALF cycles and then high for HALF cycles. last flags the final
// cycle of the final period. The counters clear whenever run is low.
// Assumes: HALF >= 1, PULSES >= 1.
module scl_burst #(
    parameter int HALF   = 60,
    parameter int PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic scl_lvl,
    output logic last
);

    localparam int CW = $clog2(2 * HALF);
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] PER_END   = CW'(2 * HALF - 1);
    localparam logic [CW-1:0] HIGH_FROM = CW'(HALF);
    localparam logic [PW-1:0] PULSE_END = PW'(PULSES - 1);

    logic [CW-1:0] phase_q;
    logic [PW-1:0] pulse_q;

    // Phase and pulse counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
            pulse_q <= '0;
        end else if (phase_q == PER_END) begin
            phase_q <= '0;
            pulse_q <= pulse_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign scl_lvl = run && (phase_q >= HIGH_FROM);
    assign last    = run && (phase_q == PER_END) && (pulse_q == PULSE_END);

    // R7: the burst never runs past its final pulse
    assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pulse_q <= PULSE_END));

endmodule

// File: rtl/pwr_seq_unlock.sv
// Supply-rail sequencer with I2C bus recovery.
// Enables rails in index order. Each rail waits for its power-good and then
// for SETTLE_CYC cycles, and a watchdog bounds the whole ramp. After the last
// settle it releases the system reset, clocks SCL SCL_PULSES times, drives a
// STOP condition and reports done. A power-good loss or a watchdog expiry
// latches FAULT with every output deasserted until rst_n is asserted.
// Assumes: 12 MHz clock, synchronous active-low rst_n, and power-good inputs
// already synchronised to clk.
module pwr_seq_unlock
    import pwrseq_pkg::*;
#(
    parameter int NUM_RAILS  = 3,
    parameter int SETTLE_CYC = 12000,
    parameter int WDOG_CYC   = 600000,
    parameter int SCL_HALF   = 60,
    parameter int SCL_PULSES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_pg,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 sys_rst_n,
    output logic                 scl_ovr_en,
    output logic                 scl_ovr_lvl,
    output logic                 sda_pull_low,
    output logic                 seq_done
);

    localparam int STOP_CYC = 3 * SCL_HALF;
    localparam int TMAX     = (SETTLE_CYC > STOP_CYC) ? SETTLE_CYC : STOP_CYC;
    localparam int TW       = $clog2(TMAX + 1);
    localparam int WW       = $clog2(WDOG_CYC + 1);
    localparam int IW       = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_RAILS - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] STOP_LD   = TW'(STOP_CYC - 1);
    localparam logic [TW-1:0] SCL_HI_BELOW = TW'(2 * SCL_HALF);
    localparam logic [TW-1:0] SDA_LO_FROM  = TW'(SCL_HALF);
    localparam logic [WW-1:0] WDOG_LD   = WW'(WDOG_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    logic [TW-1:0] tmr_count;
    logic          tmr_zero, tmr_load;
    logic [TW-1:0] tmr_ld_val;
    logic [WW-1:0] wd_count;
    logic          wd_zero;
    logic          ramping, post_reset, burst_run, burst_scl, burst_last;
    logic [NUM_RAILS-1:0] pg_needed;
    logic          pg_lost;

    assign ramping    = (state_q == ST_RAMP) || (state_q == ST_SETTLE);
    assign post_reset = (state_q == ST_BURST) || (state_q == ST_STOP) || (state_q == ST_DONE);
    assign burst_run  = (state_q == ST_BURST);

    // Which power-good inputs must currently be high
    always_comb begin
        for (int j = 0; j < NUM_RAILS; j++) begin
            pg_needed[j] = ((state_q == ST_RAMP)   && (j <  int'(idx_q))) ||
                           ((state_q == ST_SETTLE) && (j <= int'(idx_q))) ||
                           post_reset;
        end
    end

    assign pg_lost = |(pg_needed & ~rail_pg);

    // Next-state and rail-index decision
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_RAMP;
                idx_d   = '0;
            end
            ST_RAMP: begin
                if (pg_lost || wd_zero)  state_d = ST_FAULT;
                else if (rail_pg[idx_q]) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (pg_lost || wd_zero) begin
                    state_d = ST_FAULT;
                end else if (tmr_zero) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_BURST;
                    end else begin
                        state_d = ST_RAMP;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_BURST: begin
                if (pg_lost)         state_d = ST_FAULT;
                else if (burst_last) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (pg_lost)       state_d = ST_FAULT;
                else if (tmr_zero) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (pg_lost) state_d = ST_FAULT;
            end
            default: state_d = ST_FAULT;
        endcase
    end

    // State and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Phase timer is reloaded on entry to SETTLE or STOP
    assign tmr_load   = (state_d != state_q) || (idx_d != idx_q);
    assign tmr_ld_val = (state_d == ST_STOP) ? STOP_LD : SETTLE_LD;

    seq_timer #(.WIDTH(TW)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_ld_val),
        .dec      (1'b1),
        .count    (tmr_count),
        .zero     (tmr_zero)
    );

    seq_timer #(.WIDTH(WW)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_IDLE),
        .load_val (WDOG_LD),
        .dec      (ramping),
        .count    (wd_count),
        .zero     (wd_zero)
    );

    scl_burst #(.HALF(SCL_HALF), .PULSES(SCL_PULSES)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (burst_run),
        .scl_lvl (burst_scl),
        .last    (burst_last)
    );

    // Rail enables: rail i is on once the index has reached it
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        assign rail_en[g] = post_reset || (ramping && (g <= int'(idx_q)));
    end

    // Output decode
    always_comb begin
        sys_rst_n   = post_reset;
        scl_ovr_en  = burst_run || (state_q == ST_STOP);
        scl_ovr_lvl = burst_run ? burst_scl :
                      ((state_q == ST_STOP) && (tmr_count < SCL_HI_BELOW));
        // System reset gates the SDA drive
        sda_pull_low = (state_q == ST_STOP) && (tmr_count >= SDA_LO_FROM) && sys_rst_n;
        seq_done    = (state_q == ST_DONE);
    end

    // R1: a reset edge clears every output
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rail_en == '0 && !sys_rst_n && !scl_ovr_en && !scl_ovr_lvl
                    && !sda_pull_low && !seq_done));

    for (genvar g = 1; g < NUM_RAILS; g++) begin : g_chk
        // R2: enables stay cumulative
        assert_rail_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rail_en[g] |-> rail_en[g-1]);
        // R3: a rail rises only after the previous one was good
        assert_rail_after_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[g]) |-> $past(rail_pg[g-1]));
    end

    // R4: reset release only with every rail good
    assert_release_all_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(&rail_pg));

    // R5: a fault latches until reset
    assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

    // R8: SDA is only pulled while SCL is overridden
    assert_sda_with_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> scl_ovr_en);

    // R9: done means released bus, powered rails, released reset
    assert_done_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!scl_ovr_en && sys_rst_n && (&rail_en)));

endmodule

// File: tb/pwr_seq_unlock_tb.sv
module pwr_seq_unlock_tb;

    localparam int NR = 3;
    localparam int S  = 10;
    localparam int H  = 3;
    localparam int W  = 100;
    localparam int NP = 8;
    localparam int RUN_LEN = 220;
    localparam int NV = 6;

    // Power-good delays per rail, and whether a watchdog fault is expected
    localparam int VEC_D [NV][NR] = '{
        '{0, 0, 0}, '{5, 2, 7}, '{1, 20, 3}, '{0, 0, 66}, '{0, 0, 67}, '{20, 20, 30}};
    localparam bit VEC_F [NV] = '{0, 0, 0, 0, 1, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_pg = '0;
    logic [NR-1:0] rail_en;
    logic          sys_rst_n, scl_ovr_en, scl_ovr_lvl, sda_pull_low, seq_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    pwr_seq_unlock #(.NUM_RAILS(NR), .SETTLE_CYC(S), .WDOG_CYC(W),
                     .SCL_HALF(H), .SCL_PULSES(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .rail_pg(rail_pg), .rail_en(rail_en),
        .sys_rst_n(sys_rst_n), .scl_ovr_en(scl_ovr_en), .scl_ovr_lvl(scl_ovr_lvl),
        .sda_pull_low(sda_pull_low), .seq_done(seq_done));

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog on the whole run
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rail_pg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic outs_idle(input string req);
        chk(req, int'({rail_en, sys_rst_n, scl_ovr_en, scl_ovr_lvl, sda_pull_low, seq_done}), 0);
    endtask

    // Runs one vector: bench models power-good as rail_en delayed by d[i] samples
    task automatic run_vec(input int v);
        int d [NR];
        int on_cnt [NR];
        int k_on [NR];
        int k_rel, k_done, k_fault, k_sda, scl_rise, sda_bad, stop_ok, sda_cnt;
        int exp_on [NR];
        int exp_rel;
        logic prev_scl, prev_sda;
        bit was_on;
        for (int i = 0; i < NR; i++) begin
            d[i] = VEC_D[v][i]; on_cnt[i] = 0; k_on[i] = 0;
        end
        k_rel = 0; k_done = 0; k_fault = 0; k_sda = 0; scl_rise = 0;
        sda_bad = 0; stop_ok = 0; sda_cnt = 0;
        prev_scl = 1'b0; prev_sda = 1'b0; was_on = 1'b0;
        do_reset();
        for (int k = 1; k <= RUN_LEN; k++) begin
            @(negedge clk);
            for (int i = 0; i < NR; i++)
                if (rail_en[i] && k_on[i] == 0) k_on[i] = k;
            if (sys_rst_n && k_rel == 0) k_rel = k;
            if (seq_done && k_done == 0) k_done = k;
            if (rail_en != '0) was_on = 1'b1;
            if (was_on && rail_en == '0 && k_fault == 0) k_fault = k;
            if (scl_ovr_en && scl_ovr_lvl && !prev_scl) scl_rise++;
            if (sda_pull_low && !sys_rst_n) sda_bad++;
            if (sda_pull_low) begin
                sda_cnt++;
                if (k_sda == 0) k_sda = k;
            end
            if (prev_sda && !sda_pull_low && scl_ovr_en && scl_ovr_lvl) stop_ok = 1;
            prev_scl = scl_ovr_en && scl_ovr_lvl;
            prev_sda = sda_pull_low;
            for (int i = 0; i < NR; i++) begin
                if (rail_en[i]) begin
                    if (on_cnt[i] == d[i]) rail_pg[i] = 1'b1;
                    on_cnt[i]++;
                end else begin
                    rail_pg[i] = 1'b0;
                end
            end
        end
        exp_on[0] = 1;
        for (int i = 1; i < NR; i++) exp_on[i] = exp_on[i-1] + d[i-1] + 1 + S;
        exp_rel = exp_on[NR-1] + d[NR-1] + 1 + S;
        chk("R10 sda gated by reset", sda_bad, 0);
        if (VEC_F[v]) begin
            chk("R5 watchdog fault time", k_fault, W + 1);
            chk("R5 no reset release", k_rel, 0);
            chk("R5 no done", k_done, 0);
        end else begin
            chk("R2 core rail first", k_on[0], 1);
            chk("R3 ddr rail time", k_on[1], exp_on[1]);
            chk("R3 io rail time", k_on[2], exp_on[2]);
            chk("R4 reset release time", k_rel, exp_rel);
            chk("R7 sda start after burst", k_sda, exp_rel + 2 * H * NP);
            chk("R8 sda low length", sda_cnt, 2 * H);
            chk("R8 stop edge with scl high", stop_ok, 1);
            chk("R9 done time", k_done, exp_rel + 2 * H * NP + 3 * H);
            chk("R11 scl rise count", scl_rise, NP + 1);
            chk("R6 no fault", k_fault, 0);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        outs_idle("R1 reset state");

        // Table-driven sequences
        for (int v = 0; v < NV; v++) run_vec(v);

        // R2/R7: bit encoding and SCL shape on a fast sequence
        do_reset();
        rail_pg = 3'b111;
        @(negedge clk);
        chk("R2 bit0 is core rail", int'(rail_en), 1);
        // rails at 1,12,23; release at 34
        repeat (33) @(negedge clk);
        chk("R4 released at sample 34", int'(sys_rst_n), 1);
        chk("R7 scl low first half", int'({scl_ovr_en, scl_ovr_lvl}), 2);
        repeat (H) @(negedge clk);
        chk("R7 scl high second half", int'({scl_ovr_en, scl_ovr_lvl}), 3);
        chk("R7 sda released in burst", int'(sda_pull_low), 0);

        // R1: raw reset in mid burst clears everything after the edge
        rst_n = 1'b0;
        @(negedge clk);
        outs_idle("R1 reset mid burst");
        rst_n = 1'b1;

        // R6: drop a good rail after done
        rail_pg = 3'b111;
        repeat (34 + 19 * H + 2) @(negedge clk);
        chk("R9 done reached", int'(seq_done), 1);
        chk("R9 override released", int'(scl_ovr_en), 0);
        rail_pg[1] = 1'b0;
        @(negedge clk);
        outs_idle("R6 pg loss after done");

        // R5: fault ignores power-good returning
        rail_pg = 3'b111;
        repeat (20) @(negedge clk);
        outs_idle("R5 fault latched");

        // R6: pg loss of core rail during settle of rail 1
        do_reset();
        rail_pg = 3'b111;
        repeat (14) @(negedge clk);
        chk("R6 ddr rail on", int'(rail_en), 3);
        rail_pg[0] = 1'b0;
        @(negedge clk);
        outs_idle("R6 pg loss in ramp");

        finish_run();
    end

endmodule